// File: doc/BRIEF.md
# Byte-Lane Parity Checker and Generator

This block sits on one side of a 36-bit bidirectional data port that carries four 9-bit byte lanes. In each lane the top bit is the parity bit. On the inbound side it checks every lane of the bus against the parity sense chosen by an odd/even select. It reports the result on a registered, active-low error flag. The inbound word is also passed on unchanged, so the storage behind the port holds exactly what was driven.

On the outbound side the block owns the port's output register. That register loads either a word handed over by the FIFO memory or the contents of a mail register. When parity generation is requested, the parity bit of each lane is rebuilt from that lane's lower eight bits before the word is registered. The parity trees that check the inbound bus are the same trees that generate parity for mail register reads. While a mail read with generation borrows them, the error flag is forced inactive. The FIFO path has its own trees. The storage itself is outside the block: the FIFO word and the mail register contents arrive as inputs, and the block never writes them back.

Top module: `lpp_port_parity`

## Requirements
- R1: The 36-bit word is split into four lanes: bits 8:0, 17:9, 26:18 and 35:27. The parity bit of each lane is its most significant bit, at positions 8, 17, 26 and 35.
- R2: `perr_n` is registered. One cycle after a clock edge at which any lane of `bus_in` fails its parity check, it is 0. One cycle after an edge at which all four lanes pass, it is 1. This holds only when no sharing override is active at that edge.
- R3: With `odd_sel`=1 a lane passes when its nine bits hold an odd number of ones. With `odd_sel`=0 a lane passes when they hold an even number of ones.
- R4: When a word is loaded with `par_gen`=1, the parity bit of each lane in `rd_word` is replaced. The new bit makes the lane's nine bits satisfy the sense given by `odd_sel`. The lower eight bits of every lane are copied unchanged.
- R5: When a word is loaded with `par_gen`=0, `rd_word` equals the source word bit for bit.
- R6: `wr_word` always equals `bus_in`, whatever `par_gen` and `odd_sel` are.
- R7: `par_gen` and `odd_sel` take effect only as sampled on the clock edge that loads `rd_word`.
- R8: A mail read selects the mail register as the source and loads `rd_word` from `mail_word`. A mail read is `cs_n`=0, `rw_wr`=0, `en`=1 and `mb_sel`=1. If a mail read with `par_gen`=1 is present at an edge, `perr_n` is 1 after that edge, whatever `bus_in` carries.
- R9: A FIFO read loads `rd_word` from `fifo_word`. A FIFO read is `cs_n`=0, `rw_wr`=0, `en`=1, `mb_sel`=0 and `fifo_valid`=1. When neither a mail read nor a FIFO read is present, `rd_word` holds its value.
- R10: After synchronous reset, `perr_n` is 1 and `rd_word` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Port select, active low |
| rw_wr | input | 1 | 1 = write access, 0 = read access |
| en | input | 1 | Access enable |
| mb_sel | input | 1 | 1 = mail register, 0 = FIFO |
| par_gen | input | 1 | Generate parity on reads |
| odd_sel | input | 1 | 1 = odd parity, 0 = even parity |
| bus_in | input | 36 | Inbound data bus |
| fifo_word | input | 36 | Word presented by the FIFO memory |
| fifo_valid | input | 1 | FIFO memory has a word to hand over |
| mail_word | input | 36 | Contents of the mail register read by this port |
| wr_word | output | 36 | Inbound word passed to storage unchanged |
| rd_word | output | 36 | Port output register |
| perr_n | output | 1 | Parity error flag, active low |

## Verification
Suppose the shared tree input were steered wrongly. A clean bus would then raise a false error, or a mail read would carry parity built from the wrong word. Either fault shows at the ports one edge after the access. A wrong lane boundary or parity sense corrupts `rd_word` on the first generated load. It also flips `perr_n` on the first cycle whose lanes disagree. A load or hold decoded wrongly shows on `rd_word` at the next edge. An idle cycle after any load detects an unwanted update.

// File: rtl/lpp_pkg.sv
package lpp_pkg;

    parameter int unsigned LANES_DEF = 4;
    parameter int unsigned DBITS_DEF = 8;

    typedef enum logic [1:0] {
        SRC_HOLD = 2'd0,
        SRC_FIFO = 2'd1,
        SRC_MAIL = 2'd2
    } rd_src_e;

    typedef struct packed {
        logic cs_n;
        logic rw_wr;
        logic en;
        logic mb_sel;
        logic par_gen;
        logic odd_sel;
    } port_ctl_t;

    // Parity bit that makes a lane meet the selected sense, given the XOR of its data bits.
    function automatic logic gen_bit(input logic low_xor, input logic odd);
        return odd ? ~low_xor : low_xor;
    endfunction

    // Lane verdict from the XOR of all nine bits.
    function automatic logic lane_pass(input logic nine_xor, input logic odd);
        return odd ? nine_xor : ~nine_xor;
    endfunction

endpackage

// File: rtl/lpp_tree.sv
module lpp_tree #(
    parameter int unsigned LANES = lpp_pkg::LANES_DEF,
    parameter int unsigned DBITS = lpp_pkg::DBITS_DEF,
    localparam int unsigned LW   = DBITS + 1,
    localparam int unsigned W    = LANES * LW
) (
    input  logic [W-1:0]     word,
    output logic [LANES-1:0] low_x,
    output logic [LANES-1:0] nine_x
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [DBITS-1:0] data_bits;
        assign data_bits = word[l*LW +: DBITS];
        assign low_x[l]  = ^data_bits;
        assign nine_x[l] = low_x[l] ^ word[l*LW + DBITS];
    end
endmodule

// File: rtl/lpp_flag.sv
module lpp_flag #(
    parameter int unsigned LANES = lpp_pkg::LANES_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] nine_x,
    input  logic             odd_sel,
    input  logic             share,
    output logic             perr_n
);
    import lpp_pkg::*;

    logic [LANES-1:0] pass;
    logic             all_pass;

    for (genvar l = 0; l < LANES; l++) begin : g_pass
        assign pass[l] = lane_pass(nine_x[l], odd_sel);
    end
    assign all_pass = &pass;

    always_ff @(posedge clk) begin
        if (rst)
            perr_n <= 1'b1;
        else
            perr_n <= share ? 1'b1 : all_pass;
    end

    AST_FLAG_RESET: assert property (@(posedge clk) rst |=> perr_n); // R10
    AST_SHARE_HOLDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        share |=> perr_n); // R8
endmodule

// File: rtl/lpp_out.sv
module lpp_out #(
    parameter int unsigned LANES = lpp_pkg::LANES_DEF,
    parameter int unsigned DBITS = lpp_pkg::DBITS_DEF,
    localparam int unsigned LW   = DBITS + 1,
    localparam int unsigned W    = LANES * LW
) (
    input  logic              clk,
    input  logic              rst,
    input  lpp_pkg::rd_src_e  src,
    input  logic [W-1:0]      fifo_word,
    input  logic [W-1:0]      mail_word,
    input  logic [LANES-1:0]  fifo_low_x,
    input  logic [LANES-1:0]  mail_low_x,
    input  logic              par_gen,
    input  logic              odd_sel,
    output logic [W-1:0]      rd_word
);
    import lpp_pkg::*;

    logic [W-1:0]     src_word;
    logic [LANES-1:0] src_low_x;
    logic [W-1:0]     next_word;

    always_comb begin
        src_word  = fifo_word;
        src_low_x = fifo_low_x;
        if (src == SRC_MAIL) begin
            src_word  = mail_word;
            src_low_x = mail_low_x;
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_sub
        assign next_word[l*LW +: DBITS] = src_word[l*LW +: DBITS];
        assign next_word[l*LW + DBITS]  = par_gen ? gen_bit(src_low_x[l], odd_sel)
                                                  : src_word[l*LW + DBITS];

        AST_GEN_LANE_OK: assert property (@(posedge clk) disable iff (rst)
            (src != SRC_HOLD && par_gen) |=>
            (lane_pass(^rd_word[l*LW +: LW], $past(odd_sel)))); // R4
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_word <= '0;
        else if (src != SRC_HOLD)
            rd_word <= next_word;
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_HOLD) |=> $stable(rd_word)); // R9
    AST_RAW_LOAD: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_FIFO && !par_gen) |=> (rd_word == $past(fifo_word))); // R5
    AST_RAW_MAIL: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_MAIL && !par_gen) |=> (rd_word == $past(mail_word))); // R8
endmodule

// File: rtl/lpp_port_parity.sv
module lpp_port_parity #(
    parameter int unsigned LANES = lpp_pkg::LANES_DEF,
    parameter int unsigned DBITS = lpp_pkg::DBITS_DEF,
    localparam int unsigned LW   = DBITS + 1,
    localparam int unsigned W    = LANES * LW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cs_n,
    input  logic         rw_wr,
    input  logic         en,
    input  logic         mb_sel,
    input  logic         par_gen,
    input  logic         odd_sel,
    input  logic [W-1:0] bus_in,
    input  logic [W-1:0] fifo_word,
    input  logic         fifo_valid,
    input  logic [W-1:0] mail_word,
    output logic [W-1:0] wr_word,
    output logic [W-1:0] rd_word,
    output logic         perr_n
);
    import lpp_pkg::*;

    port_ctl_t        ctl;
    logic             rd_sel;
    logic             mail_rd;
    logic             share;
    rd_src_e          src;
    logic [W-1:0]     shared_in;
    logic [LANES-1:0] sh_low_x, sh_nine_x;
    logic [LANES-1:0] ff_low_x, ff_nine_x;

    assign ctl = '{cs_n: cs_n, rw_wr: rw_wr, en: en, mb_sel: mb_sel,
                   par_gen: par_gen, odd_sel: odd_sel};

    assign rd_sel  = !ctl.cs_n && !ctl.rw_wr && ctl.en;
    assign mail_rd = rd_sel && ctl.mb_sel;
    assign share   = mail_rd && ctl.par_gen;

    always_comb begin
        src = SRC_HOLD;
        if (mail_rd)
            src = SRC_MAIL;
        else if (rd_sel && fifo_valid)
            src = SRC_FIFO;
    end

    // Inbound data reaches storage untouched.
    assign wr_word = bus_in;

    // Check trees are borrowed for mail parity generation.
    assign shared_in = share ? mail_word : bus_in;

    lpp_tree #(.LANES(LANES), .DBITS(DBITS)) u_shared_tree (
        .word   (shared_in),
        .low_x  (sh_low_x),
        .nine_x (sh_nine_x)
    );

    lpp_tree #(.LANES(LANES), .DBITS(DBITS)) u_fifo_tree (
        .word   (fifo_word),
        .low_x  (ff_low_x),
        .nine_x (ff_nine_x)
    );

    lpp_flag #(.LANES(LANES)) u_flag (
        .clk     (clk),
        .rst     (rst),
        .nine_x  (sh_nine_x),
        .odd_sel (ctl.odd_sel),
        .share   (share),
        .perr_n  (perr_n)
    );

    lpp_out #(.LANES(LANES), .DBITS(DBITS)) u_out (
        .clk        (clk),
        .rst        (rst),
        .src        (src),
        .fifo_word  (fifo_word),
        .mail_word  (mail_word),
        .fifo_low_x (ff_low_x),
        .mail_low_x (sh_low_x),
        .par_gen    (ctl.par_gen),
        .odd_sel    (ctl.odd_sel),
        .rd_word    (rd_word)
    );

    AST_FLAG_TRACKS_BUS: assert property (@(posedge clk) disable iff (rst)
        !share |=> (perr_n == $past((^bus_in[8:0]   == odd_sel) && (^bus_in[17:9]  == odd_sel) &&
                                    (^bus_in[26:18] == odd_sel) && (^bus_in[35:27] == odd_sel)))); // R2
endmodule

// File: tb/lpp_port_parity_tb_top.sv
`timescale 1ns/1ps
module lpp_port_parity_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        cs_n, rw_wr, en, mb_sel, par_gen, odd_sel, fifo_valid;
    logic [35:0] bus_in, fifo_word, mail_word;
    logic [35:0] wr_word, rd_word;
    logic        perr_n;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    lpp_port_parity dut_i (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rw_wr(rw_wr), .en(en), .mb_sel(mb_sel),
        .par_gen(par_gen), .odd_sel(odd_sel), .bus_in(bus_in), .fifo_word(fifo_word),
        .fifo_valid(fifo_valid), .mail_word(mail_word), .wr_word(wr_word),
        .rd_word(rd_word), .perr_n(perr_n)
    );

    function automatic logic any_fail(input logic [35:0] w, input logic odd);
        logic f = 1'b0;
        for (int l = 0; l < 4; l++) begin
            int c = $countones(w[l*9 +: 9]);
            if (odd ? (c % 2 == 0) : (c % 2 == 1)) f = 1'b1;
        end
        return f;
    endfunction

    function automatic logic [35:0] with_par(input logic [35:0] w, input logic odd);
        logic [35:0] r = w;
        for (int l = 0; l < 4; l++) begin
            int c = $countones(w[l*9 +: 8]);
            r[l*9 + 8] = odd ? (c % 2 == 0) : (c % 2 == 1);
        end
        return r;
    endfunction

    logic [35:0] exp_rd;
    logic        exp_flag;
    string       tag_rd, tag_flag;

    task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive after a falling edge, compute expectations for the next rising edge.
    task automatic drive(input logic c, input logic rw, input logic e, input logic mb,
                         input logic pg, input logic od, input logic fv,
                         input logic [35:0] b, input logic [35:0] f, input logic [35:0] m);
        logic mrd, frd;
        cs_n = c; rw_wr = rw; en = e; mb_sel = mb; par_gen = pg; odd_sel = od;
        fifo_valid = fv; bus_in = b; fifo_word = f; mail_word = m;
        mrd = !c && !rw && e && mb;
        frd = !c && !rw && e && !mb && fv;
        if (mrd && pg) begin
            exp_flag = 1'b1; tag_flag = "R8";
        end else begin
            exp_flag = !any_fail(b, od);
            tag_flag = exp_flag ? "R3" : "R2";
        end
        if (mrd) begin
            exp_rd = pg ? with_par(m, od) : m; tag_rd = pg ? "R8_R4" : "R8_R5";
        end else if (frd) begin
            exp_rd = pg ? with_par(f, od) : f; tag_rd = pg ? "R4_R7" : "R5";
        end else begin
            tag_rd = "R9";
        end
        #0.5;
        chk("R6", wr_word, b);
    endtask

    task automatic step_check();
        @(posedge clk);
        @(negedge clk);
        chk(tag_flag, {35'd0, perr_n}, {35'd0, exp_flag});
        chk(tag_rd, rd_word, exp_rd);
    endtask

    initial begin
        #900000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [35:0] base;
        void'($urandom(32'h5eed_1234));
        rst = 1'b1;
        cs_n = 1'b1; rw_wr = 1'b0; en = 1'b0; mb_sel = 1'b0; par_gen = 1'b0;
        odd_sel = 1'b0; fifo_valid = 1'b0; bus_in = '0; fifo_word = '0; mail_word = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10", {35'd0, perr_n}, 36'd1);
        chk("R10", rd_word, 36'd0);
        rst = 1'b0;
        exp_rd = '0;

        // R1: all-zero data with odd generation sets exactly the lane MSBs.
        drive(0, 0, 1, 0, 1, 1, 1, 36'd0, 36'd0, 36'h0);
        step_check();
        chk("R1", rd_word, 36'h8_0402_0100);

        // R1: a single flipped parity bit in lane 2 is detected (even sense).
        drive(1, 1, 0, 0, 0, 0, 0, 36'h0_0400_0000, 36'd0, 36'd0);
        step_check();
        chk("R1", {35'd0, perr_n}, 36'd0);

        // R3: odd sense, all-zero bus fails; even sense passes.
        drive(1, 1, 0, 0, 0, 1, 0, 36'd0, 36'd0, 36'd0);
        step_check();
        drive(1, 1, 0, 0, 0, 0, 0, 36'd0, 36'd0, 36'd0);
        step_check();

        // R8: bad bus during mail read with generation keeps flag high.
        drive(0, 0, 1, 1, 1, 1, 0, 36'd0, 36'd0, 36'h1_2345_6789);
        step_check();

        // R7: select changes on a non-load cycle do not alter rd_word.
        drive(0, 1, 1, 0, 1, 0, 1, 36'd0, 36'hF_FFFF_FFFF, 36'd0);
        step_check();

        // R6: write path unchanged with generation on.
        drive(0, 1, 1, 1, 1, 1, 0, 36'hA_5A5A_5A5A, 36'd0, 36'd0);
        step_check();

        for (int i = 0; i < 3000; i++) begin
            logic od = 1'($urandom);
            base = with_par({$urandom, $urandom} & 36'hF_FFFF_FFFF, od);
            if ($urandom % 3 == 0) base[($urandom % 4) * 9 + ($urandom % 9)] ^= 1'b1;
            drive(1'($urandom % 4 == 0), 1'($urandom % 3 == 0), 1'($urandom % 5 != 0),
                  1'($urandom), 1'($urandom), od, 1'($urandom),
                  base, {$urandom, $urandom} & 36'hF_FFFF_FFFF,
                  {$urandom, $urandom} & 36'hF_FFFF_FFFF);
            step_check();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule